// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block gives software control over three banks of general-purpose pins, thirty per bank, through a small 32-bit register port with an address, a write strobe, write data and combinational read data. For every pin it holds a direction bit, an output value and an ownership bit. The ownership bit decides whether the pin drives its pad at all. The block also keeps a synchronized copy of the pad input, which software reads back.

Every pin can flag an event. A mode bit chooses level or edge sensing, and a polarity bit chooses high/rising or low/falling. Flags stay set until software acknowledges them by writing zero to the bit. Each bank folds its flags into one interrupt line, using only those pins that are inputs and unmasked. Edge sensing compares the synchronized input with its value one cycle earlier. Software can therefore flip a pin's polarity after each event and catch every transition in both directions.

Top module: `gpio_multibank`

## Requirements
- R1: A register sits at byte address `group*16 + bank*4`, with bank in 0..2. The group codes are: 0 direction, 2 polarity, 3 mode, 4 mask, 5 flag, 6 ownership, 7 input, 8 output. Bits 29:0 are pin bits. Bits 31:30 read as 0 and ignore writes.
- R2: While reset is held, direction reads 0x3FFFFFFF, and mask, flag, ownership and output read 0. Polarity and mode also read 0. All output enables and bank interrupts are 0.
- R3: `pad_oe` of a pin is 1 exactly when its ownership bit is 1 and its direction bit is 0 (output). `pad_out` follows the output register.
- R4: The input register shows a pad change after the second rising clock edge following that change.
- R5: With mode 1 (edge), polarity 1 flags a 0→1 input transition and polarity 0 flags a 1→0 transition. The flag is readable after the third rising edge after the pad change.
- R6: With mode 0 (level), polarity 1 flags a high input and polarity 0 flags a low input. The flag is set again on every cycle the level persists, so an acknowledge does not hold while the level is present.
- R7: Writing 0 to a flag bit clears it. Writing 1 leaves that bit unchanged.
- R8: A bank interrupt is the OR, over that bank's pins, of direction AND flag AND mask. A pin set as an output does not interrupt.
- R9: If the polarity is changed in edge mode, the next transition in the new direction is flagged.
- R10: Bank slot 3 and groups 1 and 9..15 read 0, and writes to them change no register.
- R11: Writes to the input group are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pad_in | input | 90 | Pad inputs, bank b at bits b*30 and up |
| pad_out | output | 90 | Pad output values |
| pad_oe | output | 90 | Pad output enables |
| bank_irq | output | 3 | One interrupt per bank |

## Verification
Register writes take effect on the clock edge under the strobe, so the bench reads them back in the following low phase. A pad change shows up in the input register two edges later and in the flag register and interrupt three edges later. The bench changes pads at a falling edge, then steps exactly two and three falling edges and checks both the not-yet and the now state. Output enables and interrupts are combinational from state, so the bench checks them in the same low phase as the register readback.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam logic [3:0] GRP_DIR  = 4'h0;
   localparam logic [3:0] GRP_POL  = 4'h2;
   localparam logic [3:0] GRP_MODE = 4'h3;
   localparam logic [3:0] GRP_MASK = 4'h4;
   localparam logic [3:0] GRP_FLAG = 4'h5;
   localparam logic [3:0] GRP_OWN  = 4'h6;
   localparam logic [3:0] GRP_IN   = 4'h7;
   localparam logic [3:0] GRP_OUT  = 4'h8;

   function automatic logic grp_known(input logic [3:0] g);
      return (g == GRP_DIR) || (g == GRP_POL) || (g == GRP_MODE) ||
             (g == GRP_MASK) || (g == GRP_FLAG) || (g == GRP_OWN) ||
             (g == GRP_IN) || (g == GRP_OUT);
   endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 30,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      chain_q[s] <= '0;
         else if (s == 0) chain_q[s] <= d;
         else             chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain_q[STAGES-1];

   if (STAGES == 2) begin : g_chk
      logic [1:0] primed_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               primed_q <= '0;
         else if (primed_q != 2'd2) primed_q <= primed_q + 2'd1;
      end
      // R4: two-edge latency from pad to synchronized value
      p_sync_latency_r4: assert property (@(posedge clk)
         disable iff (!rst_n || primed_q != 2'd2) q == $past(d, 2));
   end
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
   parameter int W = 30
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] prev,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] mode,
   output logic [W-1:0] hit
);
   for (genvar i = 0; i < W; i++) begin : g_pin
      logic at_level;
      logic moved;
      assign at_level = (cur[i] == pol[i]);
      assign moved    = cur[i] ^ prev[i];
      assign hit[i]   = at_level & (~mode[i] | moved);
   end
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
   import gpio_bank_pkg::*;
#(
   parameter int PINS        = 30,
   parameter int DW          = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [3:0]      grp,
   input  logic            sel,
   input  logic            we,
   input  logic [PINS-1:0] wdata,
   output logic [DW-1:0]   rd_word,
   input  logic [PINS-1:0] pad_in,
   output logic [PINS-1:0] pad_out,
   output logic [PINS-1:0] pad_oe,
   output logic            irq
);
   logic [PINS-1:0] dir_q, pol_q, mode_q, mask_q, flag_q, own_q, dout_q;
   logic [PINS-1:0] sync_q, prev_q, hit, flag_d, rd_pins;
   logic            wr_hit, wr_flag;

   assign wr_hit  = we & sel;
   assign wr_flag = wr_hit && (grp == GRP_FLAG);

   gpio_in_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q));

   gpio_trig_detect #(.W(PINS)) u_detect (
      .cur(sync_q), .prev(prev_q), .pol(pol_q), .mode(mode_q), .hit(hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '1;
         pol_q  <= '0;
         mode_q <= '0;
         mask_q <= '0;
         own_q  <= '0;
         dout_q <= '0;
      end else if (wr_hit) begin
         case (grp)
            GRP_DIR:  dir_q  <= wdata;
            GRP_POL:  pol_q  <= wdata;
            GRP_MODE: mode_q <= wdata;
            GRP_MASK: mask_q <= wdata;
            GRP_OWN:  own_q  <= wdata;
            GRP_OUT:  dout_q <= wdata;
            default:  ;
         endcase
      end
   end

   // a new event wins over an acknowledge in the same cycle
   assign flag_d = (wr_flag ? (flag_q & wdata) : flag_q) | hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         prev_q <= '0;
      end else begin
         flag_q <= flag_d;
         prev_q <= sync_q;
      end
   end

   always_comb begin
      case (grp)
         GRP_DIR:  rd_pins = dir_q;
         GRP_POL:  rd_pins = pol_q;
         GRP_MODE: rd_pins = mode_q;
         GRP_MASK: rd_pins = mask_q;
         GRP_FLAG: rd_pins = flag_q;
         GRP_OWN:  rd_pins = own_q;
         GRP_IN:   rd_pins = sync_q;
         GRP_OUT:  rd_pins = dout_q;
         default:  rd_pins = '0;
      endcase
   end

   assign rd_word = DW'(rd_pins);
   assign pad_out = dout_q;
   assign pad_oe  = own_q & ~dir_q;
   assign irq     = |(dir_q & flag_q & mask_q);

   // R5: a detected trigger is latched on the next edge
   p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((flag_q & $past(hit)) == $past(hit)));
   // R7: a flag only falls after an acknowledge write
   p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(flag_q) & ~flag_q)) |-> $past(wr_flag));
   // R8: the bank line needs a flagged input pin
   p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> |(dir_q & flag_q));
   // R11: the input group is never written from the bus
   p_in_readonly_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && grp == GRP_IN) |=> $stable(dir_q) && $stable(dout_q));
endmodule

// File: rtl/gpio_multibank.sv
module gpio_multibank
   import gpio_bank_pkg::*;
#(
   parameter int NBANK       = 3,
   parameter int PINS        = 30,
   parameter int DW          = 32,
   parameter int AW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [AW-1:0]         bus_addr,
   input  logic                  bus_we,
   input  logic [DW-1:0]         bus_wdata,
   output logic [DW-1:0]         bus_rdata,
   input  logic [NBANK*PINS-1:0] pad_in,
   output logic [NBANK*PINS-1:0] pad_out,
   output logic [NBANK*PINS-1:0] pad_oe,
   output logic [NBANK-1:0]      bank_irq
);
   localparam int SLOT_W = 2;
   localparam int NSLOT  = 1 << SLOT_W;

   if (AW < 8)         begin : g_bad_aw    $error("gpio_multibank: AW below 8");    end
   if (NBANK > NSLOT)  begin : g_bad_nbank $error("gpio_multibank: too many banks"); end
   if (PINS > DW)      begin : g_bad_pins  $error("gpio_multibank: PINS over DW");  end

   logic [3:0]        grp;
   logic [SLOT_W-1:0] slot;
   logic              hi_zero, slot_ok;
   logic [DW-1:0]     rd_word [NBANK];

   assign grp  = bus_addr[7:4];
   assign slot = bus_addr[3:2];

   if (AW > 8) begin : g_hi
      assign hi_zero = ~|bus_addr[AW-1:(AW > 8 ? 8 : 0)];
   end else begin : g_nohi
      assign hi_zero = 1'b1;
   end

   if (PINS < DW) begin : g_unused_w
      logic unused_wbits;
      assign unused_wbits = ^bus_wdata[DW-1:(PINS < DW ? PINS : 0)];
   end
   logic unused_abits;
   assign unused_abits = ^bus_addr[1:0];

   assign slot_ok = hi_zero && (32'(slot) < NBANK);

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic sel_b;
      assign sel_b = hi_zero && (slot == SLOT_W'(b));
      gpio_pin_bank #(.PINS(PINS), .DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .grp     (grp),
         .sel     (sel_b),
         .we      (bus_we),
         .wdata   (bus_wdata[PINS-1:0]),
         .rd_word (rd_word[b]),
         .pad_in  (pad_in[b*PINS +: PINS]),
         .pad_out (pad_out[b*PINS +: PINS]),
         .pad_oe  (pad_oe[b*PINS +: PINS]),
         .irq     (bank_irq[b]));
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NBANK; b++) begin
         if (hi_zero && slot == SLOT_W'(b)) bus_rdata = rd_word[b];
      end
   end

   // R10: unmapped addresses read back zero
   p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(slot_ok && grp_known(grp)) |-> bus_rdata == '0);
   // R1: the two spare bits never read as set
   p_spare_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DW-1:DW-2] == 2'b00);
endmodule

// File: tb/gpio_multibank_bench.sv
module gpio_multibank_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 3;
   localparam int NP = 30;
   localparam logic [29:0] MSK = 30'h3FFFFFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NB*NP-1:0] pad_in = '0;
   logic [NB*NP-1:0] pad_out, pad_oe;
   logic [NB-1:0]    bank_irq;

   int nchk = 0;
   int nerr = 0;
   logic done = 1'b0;

   logic [29:0] m_dir [NB];
   logic [29:0] m_pol [NB];
   logic [29:0] m_en  [NB];
   logic [29:0] m_own [NB];
   logic [29:0] m_out [NB];

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_multibank u_gpio_multibank (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .bank_irq(bank_irq));

   function automatic logic [7:0] ra(input int g, input int b);
      return 8'(g*16 + b*4);
   endfunction

   function automatic logic [89:0] exp_oe();
      logic [89:0] v;
      for (int b = 0; b < NB; b++) v[b*NP +: NP] = m_own[b] & ~m_dir[b];
      return v;
   endfunction

   function automatic logic [89:0] exp_out();
      logic [89:0] v;
      for (int b = 0; b < NB; b++) v[b*NP +: NP] = m_out[b];
      return v;
   endfunction

   task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, 96'(v), 96'(exp));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd1234));
      for (int b = 0; b < NB; b++) begin
         m_dir[b] = MSK; m_pol[b] = '0; m_en[b] = '0; m_own[b] = '0; m_out[b] = '0;
      end

      // R2: state while reset is held
      step(3);
      for (int b = 0; b < NB; b++) begin
         rchk("R2 dir", ra(0, b), 32'h3FFFFFFF);
         rchk("R2 flag", ra(5, b), 32'h0);
         rchk("R2 mask", ra(4, b), 32'h0);
         rchk("R2 own", ra(6, b), 32'h0);
         rchk("R2 out", ra(8, b), 32'h0);
         rchk("R2 pol", ra(2, b), 32'h0);
      end
      chk("R2 oe", 96'(pad_oe), 96'h0);
      chk("R2 irq", 96'(bank_irq), 96'h0);

      rst_n = 1'b1;
      step(3);
      // R6: default level-low mode with low pads flags every pin
      rchk("R6 level low after reset", ra(5, 0), 32'h3FFFFFFF);
      wr(ra(5, 0), 32'h0);
      rchk("R6 ack does not hold", ra(5, 0), 32'h3FFFFFFF);

      for (int b = 0; b < NB; b++) wr(ra(3, b), 32'hFFFFFFFF);
      for (int b = 0; b < NB; b++) wr(ra(5, b), 32'h0);
      for (int b = 0; b < NB; b++) rchk("R7 ack to zero", ra(5, b), 32'h0);

      // R1: spare bits
      wr(ra(0, 1), 32'hFFFFFFFF);
      rchk("R1 spare bits zero", ra(0, 1), 32'h3FFFFFFF);

      // R1 R3 R8: random register traffic with quiet pads
      for (int i = 0; i < 40; i++) begin
         int b, k, g;
         logic [31:0] d;
         b = int'($urandom % 3);
         k = int'($urandom % 5);
         d = $urandom;
         g = (k == 0) ? 0 : (k == 1) ? 2 : (k == 2) ? 4 : (k == 3) ? 6 : 8;
         wr(ra(g, b), d);
         case (g)
            0: m_dir[b] = d[29:0];
            2: m_pol[b] = d[29:0];
            4: m_en[b]  = d[29:0];
            6: m_own[b] = d[29:0];
            default: m_out[b] = d[29:0];
         endcase
         rchk("R1 readback", ra(g, b), {2'b00, d[29:0]});
         chk("R3 pad_oe", 96'(pad_oe), 96'(exp_oe()));
         chk("R3 pad_out", 96'(pad_out), 96'(exp_out()));
         chk("R8 no flags no irq", 96'(bank_irq), 96'h0);
      end

      // R10: unmapped slots and groups
      rchk("R10 slot 3", 8'h0C, 32'h0);
      rchk("R10 group 1", 8'h14, 32'h0);
      rchk("R10 group 9", 8'h94, 32'h0);
      wr(8'h0C, 32'hFFFFFFFF);
      wr(8'h10, 32'hFFFFFFFF);
      for (int b = 0; b < NB; b++) rchk("R10 dir untouched", ra(0, b), {2'b00, m_dir[b]});
      // R11: input group ignores writes
      wr(ra(7, 0), 32'hFFFFFFFF);
      rchk("R11 input unchanged", ra(7, 0), 32'h0);

      // set up bank 1 pin 3 for edge work, bank 0 and 2 masked
      for (int b = 0; b < NB; b++) begin
         wr(ra(0, b), 32'hFFFFFFFF); m_dir[b] = MSK;
         wr(ra(4, b), 32'h0);        m_en[b] = '0;
      end
      wr(ra(2, 1), 32'h8);
      wr(ra(4, 1), 32'h8);

      // R4 R5: rising edge
      @(negedge clk);
      pad_in[33] = 1'b1;
      step(2);
      rchk("R4 input after two edges", ra(7, 1), 32'h8);
      rchk("R5 not yet flagged", ra(5, 1), 32'h0);
      step(1);
      rchk("R5 rising flagged", ra(5, 1), 32'h8);
      chk("R8 irq bank1", 96'(bank_irq), 96'h2);

      // R8: output pin does not interrupt
      wr(ra(0, 1), 32'h3FFFFFF7);
      chk("R8 output pin masked", 96'(bank_irq), 96'h0);
      wr(ra(0, 1), 32'h3FFFFFFF);
      chk("R8 input again", 96'(bank_irq), 96'h2);

      // R7: write one keeps, write zero clears
      wr(ra(5, 1), 32'hFFFFFFFF);
      rchk("R7 write one keeps", ra(5, 1), 32'h8);
      wr(ra(5, 1), 32'h0);
      rchk("R7 write zero clears", ra(5, 1), 32'h0);
      chk("R7 irq drops", 96'(bank_irq), 96'h0);

      // R5: falling edge with polarity 0
      wr(ra(2, 1), 32'h0);
      rchk("R5 no event on pol change", ra(5, 1), 32'h0);
      @(negedge clk);
      pad_in[33] = 1'b0;
      step(2);
      rchk("R5 falling not yet", ra(5, 1), 32'h0);
      step(1);
      rchk("R5 falling flagged", ra(5, 1), 32'h8);
      wr(ra(5, 1), 32'h0);

      // R9: flip polarity, next rise is caught
      wr(ra(2, 1), 32'h8);
      @(negedge clk);
      pad_in[33] = 1'b1;
      step(3);
      rchk("R9 flipped polarity caught", ra(5, 1), 32'h8);
      wr(ra(5, 1), 32'h0);

      // R6: level-high on bank 2 pin 5
      wr(ra(2, 2), 32'h20);
      wr(ra(3, 2), 32'h3FFFFFDF);
      wr(ra(4, 2), 32'h20);
      step(3);
      rchk("R6 inactive level", ra(5, 2), 32'h0);
      pad_in[65] = 1'b1;
      step(3);
      rchk("R6 high level flagged", ra(5, 2), 32'h20);
      chk("R6 irq bank2", 96'(bank_irq), 96'h4);
      wr(ra(5, 2), 32'h0);
      rchk("R6 ack while high", ra(5, 2), 32'h20);
      pad_in[65] = 1'b0;
      step(3);
      wr(ra(5, 2), 32'h0);
      rchk("R6 ack after level gone", ra(5, 2), 32'h0);
      chk("R6 irq off", 96'(bank_irq), 96'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule